// File: doc/BRIEF.md
# Valley Lockout Mode Selector

This block decides which drain-voltage valley starts the next switching cycle of a quasi-resonant flyback converter. A digitized feedback level, in millivolts, selects one of four locked valleys or a low-frequency mode. Separate thresholds for falling and rising feedback give hysteresis, so the selection does not chatter between neighbouring valleys. The selection is only re-evaluated at the cycle-end strobe, which marks driver turn-off. It moves by at most one step per cycle.

During the off-time the block counts valley-detect pulses from the demagnetization comparator. It raises a one-cycle turn-on request when the count reaches the locked valley. In the low-frequency mode it instead waits for an external "period due" pulse and then starts on the next valley.

Several guards apply to the turn-on request:
- Different dead times block valley acceptance when the block enters or leaves the low-frequency mode.
- A demagnetization timeout forces a restart when the valley pulses stop.
- A selectable minimum-period clamp holds back a request that is too early.
- An on-time limit flags an on-time that has run too long.

Top module: `valley_lock_sel`

## Requirements
- R1: While reset is asserted, valley_sel is 1, vco_mode is 0, turn_on_req is 0 and ton_limit is 0. On the first clock after reset is released, the mode is loaded from fb_mv: the low-frequency mode (valley_sel 0, vco_mode 1) if fb_mv < 1900, otherwise valley 1.
- R2: At a cycle_end strobe with falling feedback, the mode steps down one place when fb_mv is strictly below the threshold: valley 1 to 2 below 2500, valley 2 to 3 below 2300, valley 3 to 4 below 2100, valley 4 to the low-frequency mode below 1900. A value equal to the threshold causes no step.
- R3: At a cycle_end strobe with rising feedback, the mode steps up one place when fb_mv is strictly above the threshold: low-frequency mode to valley 4 above 2500, valley 4 to 3 above 2700, valley 3 to 2 above 2900, valley 2 to 1 above 3100. The mode moves at most one place per strobe and never changes without a strobe.
- R4: After a cycle_end, turn_on_req pulses high for one cycle, in the cycle after the valley_pulse whose count equals valley_sel. Valley pulses are ignored between a turn-on request and the next cycle_end.
- R5: When a cycle_end moves the mode from valley 4 to the low-frequency mode, valley pulses sampled in the 230 cycles after that strobe are ignored. A pulse sampled later is accepted.
- R6: When a cycle_end moves the mode from the low-frequency mode to valley 4, valley pulses sampled in the 130 cycles after that strobe are ignored. An ignored pulse is not counted.
- R7: In the low-frequency mode, a valley pulse causes a turn-on only if a vco_due pulse was seen since the last cycle_end.
- R8: Suppose a turn-on is pending and no valley pulse arrives for 900 cycles after the last valley pulse or cycle_end. Then turn_on_req is forced high in the cycle after the 900th cycle.
- R9: clamp_sel selects the minimum period between turn-on requests: 0 none, 1 gives 2500 cycles, 2 gives 1818 cycles, 3 gives 1428 cycles. A request that is due earlier is held until the first valley pulse sampled at least that many cycles after the previous request.
- R10: If no cycle_end follows a turn-on request within 7200 cycles, ton_limit pulses high for one cycle, 7200 cycles after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 200 MHz nominal |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_mv | input | 12 | Feedback level in millivolts |
| valley_pulse | input | 1 | One-cycle valley-detect pulse |
| cycle_end | input | 1 | One-cycle strobe at driver turn-off |
| vco_due | input | 1 | Low-frequency period elapsed pulse |
| clamp_sel | input | 2 | Minimum period select: 0 none, 1 80 kHz, 2 110 kHz, 3 140 kHz |
| valley_sel | output | 3 | Locked valley 1..4, 0 in low-frequency mode |
| vco_mode | output | 1 | High in low-frequency mode |
| turn_on_req | output | 1 | One-cycle turn-on request |
| ton_limit | output | 1 | One-cycle on-time limit flag |

## Verification
The hardest situations to reach are the edges of each timing window: the exact cycle where a dead time ends, and the exact cycle where the minimum period expires. The pending timeout also saturates during a clamp hold and could fire in that same cycle, which would hide the valley result.

The stimulus keeps a free-running cycle index and places each valley pulse on an exact sampling edge relative to the strobe or to the previous request. It puts an early rejected valley just before each boundary, which also restarts the timeout, so the accepted pulse alone explains the request.

// File: rtl/vls_pkg.sv
`timescale 1ns/1ps
package vls_pkg;
  typedef enum logic [2:0] {
    M_V1  = 3'd1,
    M_V2  = 3'd2,
    M_V3  = 3'd3,
    M_V4  = 3'd4,
    M_VCO = 3'd5
  } vmode_e;

  function automatic logic [2:0] valley_num(input vmode_e m);
    return (m == M_VCO) ? 3'd0 : 3'(m);
  endfunction
endpackage

// File: rtl/vls_hyst.sv
`timescale 1ns/1ps
module vls_hyst import vls_pkg::*; #(
  parameter int unsigned      FB_W   = 12,
  parameter logic [FB_W-1:0]  TH_D12 = FB_W'(2500),
  parameter logic [FB_W-1:0]  TH_D23 = FB_W'(2300),
  parameter logic [FB_W-1:0]  TH_D34 = FB_W'(2100),
  parameter logic [FB_W-1:0]  TH_D4V = FB_W'(1900),
  parameter logic [FB_W-1:0]  TH_UV4 = FB_W'(2500),
  parameter logic [FB_W-1:0]  TH_U43 = FB_W'(2700),
  parameter logic [FB_W-1:0]  TH_U32 = FB_W'(2900),
  parameter logic [FB_W-1:0]  TH_U21 = FB_W'(3100)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FB_W-1:0] fb,
  input  logic            cycle_end,
  output vmode_e          mode_q,
  output logic            enter_vco,
  output logic            leave_vco
);
  logic   init_q;
  logic   init_d;
  vmode_e step;
  vmode_e mode_d;

  // one-place hysteretic step from the current mode
  always_comb begin
    case (mode_q)
      M_V1:    step = (fb < TH_D12) ? M_V2 : M_V1;
      M_V2:    step = (fb < TH_D23) ? M_V3 : ((fb > TH_U21) ? M_V1 : M_V2);
      M_V3:    step = (fb < TH_D34) ? M_V4 : ((fb > TH_U32) ? M_V2 : M_V3);
      M_V4:    step = (fb < TH_D4V) ? M_VCO : ((fb > TH_U43) ? M_V3 : M_V4);
      M_VCO:   step = (fb > TH_UV4) ? M_V4 : M_VCO;
      default: step = M_V1;
    endcase
  end

  always_comb begin
    init_d = 1'b0;
    mode_d = mode_q;
    if (init_q) begin
      mode_d = (fb < TH_D4V) ? M_VCO : M_V1;
    end else if (cycle_end) begin
      mode_d = step;
    end
  end

  assign enter_vco = !init_q && cycle_end && (mode_q == M_V4)  && (step == M_VCO);
  assign leave_vco = !init_q && cycle_end && (mode_q == M_VCO) && (step == M_V4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_V1;
      init_q <= 1'b1;
    end else begin
      mode_q <= mode_d;
      init_q <= init_d;
    end
  end

  // R3: selection holds between strobes
  a_r3_hold_between_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (!cycle_end && !init_q) |=> $stable(mode_q));

  // R3: never more than one place per strobe
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !init_q |=> ((3'(mode_q) == 3'($past(mode_q))) ||
                 (3'(mode_q) == 3'(3'($past(mode_q)) + 3'd1)) ||
                 (3'(3'(mode_q) + 3'd1) == 3'($past(mode_q)))));
endmodule

// File: rtl/vls_guard.sv
`timescale 1ns/1ps
module vls_guard #(
  parameter int unsigned DT_ENTER = 230,
  parameter int unsigned DT_LEAVE = 130,
  parameter int unsigned P_SLOW   = 2500,
  parameter int unsigned P_MID    = 1818,
  parameter int unsigned P_FAST   = 1428,
  parameter int unsigned TON_MAX  = 7200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cycle_end,
  input  logic       fire,
  input  logic       enter_vco,
  input  logic       leave_vco,
  input  logic [1:0] clamp_sel,
  output logic       dt_busy,
  output logic       clamp_ok,
  output logic       ton_limit
);
  localparam int unsigned DT_MAX = (DT_ENTER > DT_LEAVE) ? DT_ENTER : DT_LEAVE;
  localparam int unsigned DW     = $clog2(DT_MAX + 1);
  localparam int unsigned P_AB   = (P_SLOW > P_MID) ? P_SLOW : P_MID;
  localparam int unsigned P_MAX  = (P_AB > P_FAST) ? P_AB : P_FAST;
  localparam int unsigned CW     = $clog2(P_MAX + 1);
  localparam int unsigned OW     = $clog2(TON_MAX + 1);
  localparam logic [DW-1:0] DT_EN_V = DW'(DT_ENTER);
  localparam logic [DW-1:0] DT_LV_V = DW'(DT_LEAVE);
  localparam logic [CW-1:0] P_SAT   = CW'(P_MAX);
  localparam logic [OW-1:0] T_SAT   = OW'(TON_MAX);
  localparam logic [OW-1:0] T_LAST  = OW'(TON_MAX - 1);

  logic [DW-1:0] dt_q, dt_d;
  logic [CW-1:0] cl_q, cl_d, plim;
  logic [OW-1:0] ton_q, ton_d;
  logic          on_q, on_d, lim_q, lim_d;

  // dead time after a low-frequency mode transition
  always_comb begin
    dt_d = dt_q;
    if (enter_vco) begin
      dt_d = DT_EN_V;
    end else if (leave_vco) begin
      dt_d = DT_LV_V;
    end else if (dt_q != '0) begin
      dt_d = dt_q - 1'b1;
    end
  end
  assign dt_busy = (dt_q != '0);

  // minimum period since the previous turn-on
  always_comb begin
    case (clamp_sel)
      2'd1:    plim = CW'(P_SLOW - 1);
      2'd2:    plim = CW'(P_MID - 1);
      2'd3:    plim = CW'(P_FAST - 1);
      default: plim = '0;
    endcase
  end
  assign clamp_ok = (clamp_sel == 2'd0) || (cl_q >= plim);

  always_comb begin
    cl_d = cl_q;
    if (fire) begin
      cl_d = '0;
    end else if (cl_q != P_SAT) begin
      cl_d = cl_q + 1'b1;
    end
  end

  // on-time limit
  always_comb begin
    on_d  = on_q;
    ton_d = ton_q;
    if (fire) begin
      on_d  = 1'b1;
      ton_d = '0;
    end else begin
      if (cycle_end) on_d = 1'b0;
      if (on_q && (ton_q != T_SAT)) ton_d = ton_q + 1'b1;
    end
    lim_d = on_q && !cycle_end && !fire && (ton_q == T_LAST);
  end
  assign ton_limit = lim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dt_q  <= '0;
      cl_q  <= P_SAT;
      on_q  <= 1'b0;
      ton_q <= '0;
      lim_q <= 1'b0;
    end else begin
      dt_q  <= dt_d;
      cl_q  <= cl_d;
      on_q  <= on_d;
      ton_q <= ton_d;
      lim_q <= lim_d;
    end
  end

  // independent spacing counter for the period check
  logic [CW-1:0] chk_since;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_since <= P_SAT;
    end else if (fire) begin
      chk_since <= '0;
    end else if (chk_since != P_SAT) begin
      chk_since <= chk_since + 1'b1;
    end
  end

  // R5: no start while a dead time runs
  a_r5_dead_time_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    dt_busy |-> !fire);

  // R9: starts are spaced by the selected period
  a_r9_min_period: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (clamp_sel != 2'd0)) |-> (chk_since >= plim));

  // R10: the limit flag is a single pulse
  a_r10_single_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ton_limit |=> !ton_limit);
endmodule

// File: rtl/vls_seq.sv
`timescale 1ns/1ps
module vls_seq import vls_pkg::*; #(
  parameter int unsigned TOUT_CYC = 900
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   valley_pulse,
  input  logic   cycle_end,
  input  logic   vco_due,
  input  vmode_e mode,
  input  logic   dt_busy,
  input  logic   clamp_ok,
  output logic   fire,
  output logic   turn_on_req
);
  localparam int unsigned TW = $clog2(TOUT_CYC + 1);
  localparam logic [TW-1:0] T_LAST = TW'(TOUT_CYC - 1);
  localparam logic [TW-1:0] T_SAT  = TW'(TOUT_CYC);

  logic          wait_q, wait_d, vok_q, vok_d, req_q;
  logic [2:0]    vcnt_q, vcnt_d;
  logic [TW-1:0] tout_q, tout_d;
  logic          is_vco, accept, target, tout_hit;

  assign is_vco   = (mode == M_VCO);
  assign accept   = valley_pulse && wait_q && !dt_busy && !cycle_end;
  assign target   = is_vco ? vok_q :
                    (({1'b0, vcnt_q} + 4'd1) >= {1'b0, valley_num(mode)});
  assign tout_hit = wait_q && !cycle_end && (tout_q >= T_LAST) && !dt_busy &&
                    clamp_ok && (!is_vco || vok_q);
  assign fire     = (accept && target && clamp_ok) || tout_hit;

  always_comb begin
    wait_d = wait_q;
    vcnt_d = vcnt_q;
    tout_d = tout_q;
    vok_d  = vok_q;
    if (cycle_end) begin
      wait_d = 1'b1;
      vcnt_d = '0;
      tout_d = '0;
      vok_d  = 1'b0;
    end else begin
      if (fire) wait_d = 1'b0;
      if (accept && (vcnt_q != 3'd7)) vcnt_d = vcnt_q + 3'd1;
      if (valley_pulse && wait_q) begin
        tout_d = '0;
      end else if (wait_q && (tout_q != T_SAT)) begin
        tout_d = tout_q + 1'b1;
      end
      if (vco_due) vok_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= 1'b1;
      vcnt_q <= '0;
      tout_q <= '0;
      vok_q  <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      wait_q <= wait_d;
      vcnt_q <= vcnt_d;
      tout_q <= tout_d;
      vok_q  <= vok_d;
      req_q  <= fire;
    end
  end
  assign turn_on_req = req_q;

  // R4: one request per off-time
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    turn_on_req |=> !turn_on_req);

  // R4: no request outside the off-time
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !wait_q |=> !turn_on_req);

  // R7: low-frequency mode needs a period-due pulse
  a_r7_vco_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (is_vco && !vok_q) |=> !turn_on_req);
endmodule

// File: rtl/valley_lock_sel.sv
`timescale 1ns/1ps
module valley_lock_sel import vls_pkg::*; #(
  parameter int unsigned FB_W     = 12,
  parameter int unsigned DT_ENTER = 230,
  parameter int unsigned DT_LEAVE = 130,
  parameter int unsigned TOUT_CYC = 900,
  parameter int unsigned P_SLOW   = 2500,
  parameter int unsigned P_MID    = 1818,
  parameter int unsigned P_FAST   = 1428,
  parameter int unsigned TON_MAX  = 7200
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FB_W-1:0] fb_mv,
  input  logic            valley_pulse,
  input  logic            cycle_end,
  input  logic            vco_due,
  input  logic [1:0]      clamp_sel,
  output logic [2:0]      valley_sel,
  output logic            vco_mode,
  output logic            turn_on_req,
  output logic            ton_limit
);
  vmode_e mode;
  logic   enter_vco, leave_vco, dt_busy, clamp_ok, fire;

  vls_hyst #(.FB_W(FB_W)) u_hyst (
    .clk(clk), .rst_n(rst_n), .fb(fb_mv), .cycle_end(cycle_end),
    .mode_q(mode), .enter_vco(enter_vco), .leave_vco(leave_vco)
  );

  vls_guard #(
    .DT_ENTER(DT_ENTER), .DT_LEAVE(DT_LEAVE), .P_SLOW(P_SLOW),
    .P_MID(P_MID), .P_FAST(P_FAST), .TON_MAX(TON_MAX)
  ) u_guard (
    .clk(clk), .rst_n(rst_n), .cycle_end(cycle_end), .fire(fire),
    .enter_vco(enter_vco), .leave_vco(leave_vco), .clamp_sel(clamp_sel),
    .dt_busy(dt_busy), .clamp_ok(clamp_ok), .ton_limit(ton_limit)
  );

  vls_seq #(.TOUT_CYC(TOUT_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .valley_pulse(valley_pulse),
    .cycle_end(cycle_end), .vco_due(vco_due), .mode(mode),
    .dt_busy(dt_busy), .clamp_ok(clamp_ok), .fire(fire),
    .turn_on_req(turn_on_req)
  );

  assign valley_sel = valley_num(mode);
  assign vco_mode   = (mode == M_VCO);
endmodule

// File: tb/sim_valley_lock_sel.sv
`timescale 1ns/1ps
module sim_valley_lock_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] fb_mv = 12'd3000;
  logic        valley_pulse = 1'b0;
  logic        cycle_end = 1'b0;
  logic        vco_due = 1'b0;
  logic [1:0]  clamp_sel = 2'd0;
  logic [2:0]  valley_sel;
  logic        vco_mode, turn_on_req, ton_limit;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int t_end = 0;
  int t_req = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  valley_lock_sel u0 (
    .clk(clk), .rst_n(rst_n), .fb_mv(fb_mv), .valley_pulse(valley_pulse),
    .cycle_end(cycle_end), .vco_due(vco_due), .clamp_sel(clamp_sel),
    .valley_sel(valley_sel), .vco_mode(vco_mode),
    .turn_on_req(turn_on_req), .ton_limit(ton_limit)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  task automatic wait_cyc(input int x);
    while (cyc < x) @(negedge clk);
  endtask

  task automatic valley();
    @(negedge clk); valley_pulse = 1'b1;
    @(negedge clk); valley_pulse = 1'b0;
  endtask

  task automatic valley_at(input int x);
    wait_cyc(x - 1);
    valley_pulse = 1'b1;
    @(negedge clk); valley_pulse = 1'b0;
  endtask

  task automatic vco_pulse();
    @(negedge clk); vco_due = 1'b1;
    @(negedge clk); vco_due = 1'b0;
  endtask

  task automatic end_cycle(input int v);
    fb_mv = 12'(v);
    @(negedge clk); cycle_end = 1'b1;
    @(negedge clk); cycle_end = 1'b0;
    t_end = cyc;
  endtask

  task automatic fire_n(input int n, input string tag);
    for (int i = 1; i <= n; i++) begin
      valley();
      chk(tag, int'(turn_on_req), (i == n) ? 1 : 0);
    end
    t_req = cyc;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; fb_mv = 12'd3000;
    repeat (3) @(negedge clk);
    chk("R1 reset valley_sel", int'(valley_sel), 1);
    chk("R1 reset vco_mode", int'(vco_mode), 0);
    chk("R1 reset turn_on_req", int'(turn_on_req), 0);
    chk("R1 reset ton_limit", int'(ton_limit), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 high feedback start", int'(valley_sel), 1);
    rst_n = 1'b0; fb_mv = 12'd1800;
    repeat (2) @(negedge clk);
    chk("R1 in reset low feedback", int'(valley_sel), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 low feedback start vco", int'(vco_mode), 1);
    chk("R1 low feedback start sel", int'(valley_sel), 0);
    rst_n = 1'b0; fb_mv = 12'd3000;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    fire_n(1, "R4 first valley after reset");
  endtask

  task automatic t_falling();
    end_cycle(2500);
    chk("R2 equal 2500 stays 1", int'(valley_sel), 1);
    fire_n(1, "R4 valley1");
    end_cycle(2499);
    chk("R2 below 2500 to 2", int'(valley_sel), 2);
    fire_n(2, "R4 valley2");
    valley();
    chk("R4 ignored while on", int'(turn_on_req), 0);
    end_cycle(3000);
    chk("R3 3000 holds 2", int'(valley_sel), 2);
    fire_n(2, "R4 valley2 after on pulse");
    end_cycle(2299);
    chk("R2 below 2300 to 3", int'(valley_sel), 3);
    fire_n(3, "R4 valley3");
    end_cycle(2099);
    chk("R2 below 2100 to 4", int'(valley_sel), 4);
    fire_n(4, "R4 valley4");
  endtask

  task automatic t_vco();
    end_cycle(1899);
    chk("R2 below 1900 to vco", int'(vco_mode), 1);
    vco_pulse();
    valley_at(t_end + 230);
    chk("R5 valley in enter dead time", int'(turn_on_req), 0);
    valley_at(t_end + 232);
    chk("R5 valley after enter dead time", int'(turn_on_req), 1);
    end_cycle(2500);
    chk("R3 equal 2500 stays vco", int'(vco_mode), 1);
    valley();
    chk("R7 no period-due pulse", int'(turn_on_req), 0);
    vco_pulse();
    valley();
    chk("R7 valley after period-due", int'(turn_on_req), 1);
    end_cycle(2501);
    chk("R3 above 2500 to 4", int'(valley_sel), 4);
    valley_at(t_end + 130);
    chk("R6 valley in leave dead time", int'(turn_on_req), 0);
    valley_at(t_end + 132);
    chk("R6 first counted valley", int'(turn_on_req), 0);
    fire_n(3, "R6 ignored valley not counted");
  endtask

  task automatic t_rising();
    end_cycle(2700);
    chk("R3 equal 2700 stays 4", int'(valley_sel), 4);
    fire_n(4, "R4 valley4 again");
    end_cycle(2701);
    chk("R3 above 2700 to 3", int'(valley_sel), 3);
    fire_n(3, "R4 valley3 rising");
    end_cycle(2901);
    chk("R3 above 2900 to 2", int'(valley_sel), 2);
    fire_n(2, "R4 valley2 rising");
    end_cycle(3101);
    chk("R3 above 3100 to 1", int'(valley_sel), 1);
    fire_n(1, "R4 valley1 rising");
    fb_mv = 12'd1000;
    repeat (20) @(negedge clk);
    chk("R3 no change without strobe", int'(valley_sel), 1);
    end_cycle(1000);
    chk("R3 one place per strobe", int'(valley_sel), 2);
    fire_n(2, "R4 valley2 after single step");
  endtask

  task automatic t_timeout();
    int hit;
    end_cycle(2499);
    hit = 0;
    while (cyc < t_end + 899) begin
      @(negedge clk);
      if (turn_on_req) hit = 1;
    end
    chk("R8 no early timeout", hit, 0);
    @(negedge clk);
    chk("R8 timeout after cycle end", int'(turn_on_req), 1);
    end_cycle(2499);
    valley_at(t_end + 500);
    t_req = cyc;
    chk("R8 one valley not enough", int'(turn_on_req), 0);
    wait_cyc(t_req + 899);
    chk("R8 valley restarts timeout", int'(turn_on_req), 0);
    @(negedge clk);
    chk("R8 timeout after last valley", int'(turn_on_req), 1);
    end_cycle(3200);
    chk("R3 above 3100 back to 1", int'(valley_sel), 1);
    fire_n(1, "R4 valley1 before clamp");
  endtask

  task automatic clamp_run(input logic [1:0] sel, input int p, input int rej, input int acc);
    clamp_sel = 2'd0;
    end_cycle(3200);
    fire_n(1, "R9 baseline start");
    clamp_sel = sel;
    end_cycle(3200);
    valley_at(t_req + 5);
    chk("R9 early valley held", int'(turn_on_req), 0);
    valley_at(t_req + p + rej);
    chk("R9 valley before period", int'(turn_on_req), 0);
    valley_at(t_req + p + acc);
    chk("R9 valley after period", int'(turn_on_req), 1);
    t_req = cyc;
  endtask

  task automatic t_ontime();
    int base;
    base = t_req;
    wait_cyc(base + 7199);
    chk("R10 no flag before limit", int'(ton_limit), 0);
    @(negedge clk);
    chk("R10 flag at limit", int'(ton_limit), 1);
    @(negedge clk);
    chk("R10 flag single pulse", int'(ton_limit), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    report();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_falling();
    t_vco();
    t_rising();
    t_timeout();
    clamp_run(2'd3, 1428, -2, 0);
    clamp_run(2'd1, 2500, -1, 1);
    clamp_run(2'd2, 1818, -1, 1);
    t_ontime();
    report();
  end
endmodule